// File: doc/BRIEF.md
# Programmable Hysteresis Field Switch

This block turns a stream of digitised magnetic field samples into a single switch decision with hysteresis. Samples are signed values in gauss and arrive with a one-cycle valid strobe. An 8-bit magnitude code sets the operate threshold along a linear scale. A direction bit mirrors that scale so the same core can trip on south or on north fields. The release threshold always sits a fixed hysteresis distance back from the operate threshold, on the side away from the operate direction. Between the two thresholds the switch keeps its last decision.

An output-sense bit chooses whether the operated state pulls the output pin low or lets it float high. The block does not drive the pin itself. It raises an open-drain pull-down enable, `drv_en`, whenever the pin should be low. Turn-on means the pull-down engages. A 2-bit slow-edge code delays turn-on by 0 to 3 steps of a configurable number of clock cycles. Turn-off is never delayed. While the power-good input is low, the switch is held released.

The decision machine has two states. In `SW_RELEASED`, the transition *operate* to `SW_OPERATED` is taken when a valid sample lies beyond the operate threshold. In `SW_OPERATED`, the transition *release* back is taken when a valid sample lies past the release threshold. A power-loss transition forces `SW_RELEASED` from either state. The drive machine has three states. From `DR_IDLE`, *request* moves to `DR_WAIT`, or *immediate* moves straight to `DR_DRIVE` when the delay code is 0. In `DR_WAIT`, *expire* moves to `DR_DRIVE`, and *cancel* returns to `DR_IDLE` if the pin should no longer be low. From `DR_DRIVE`, *drop* returns to `DR_IDLE`.

Top module: `field_switch_top`

## Requirements
- R1: With `op_dir`=0, the operate threshold is -20 + 3*`op_code` gauss. A valid sample strictly greater than that threshold, taken while released, makes `sw_active` 1 after that clock edge.
- R2: With `op_dir`=0, a valid sample strictly below (operate threshold - 15) returns `sw_active` to 0. Samples from the release threshold up to the operate threshold leave the state unchanged.
- R3: With `op_dir`=1, the operate threshold is 20 - 3*`op_code`. A sample strictly below it operates the switch. A sample strictly above (threshold + 15) releases it, and samples in between hold the state.
- R4: A field value presented while `field_valid` is 0 has no effect on `sw_active` or `drv_en`.
- R5: `drv_en` may be 1 only when the pin should be low. With `out_inv`=0 that is when `sw_active`=1. With `out_inv`=1 it is when `sw_active`=0.
- R6: While `pwr_ok` is 0 at a clock edge, the switch goes to the released state. After power returns on the release side, `drv_en` is 0 (pin high) for `out_inv`=0 and becomes 1 (pin low) for `out_inv`=1.
- R7: Count from the clock edge at which the pin should first become low. `drv_en` then rises exactly 1 + 4*`fall_sel` edges later (default step of 4 cycles) and not earlier.
- R8: `drv_en` falls on the same clock edge at which the pin should become high, for every `fall_sel`.
- R9: If the pin should become high again before a pending turn-on delay expires, `drv_en` does not assert at all.
- R10: The scale ends are honoured. For `op_dir`=0 and code 255 the switch operates above +745 and releases below +730. For `op_dir`=1 and code 0 it operates below +20 and releases above +35.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_ok | input | 1 | Power-good indication; low forces the released state |
| field_valid | input | 1 | Strobe marking `field` as a new sample |
| field | input | 12 | Signed field sample in gauss |
| op_code | input | 8 | Operate threshold magnitude code |
| op_dir | input | 1 | Threshold direction: 0 south (rising), 1 north (falling) |
| out_inv | input | 1 | Output sense: 1 makes the released state pull the pin low |
| fall_sel | input | 2 | Turn-on delay in steps of 4 clock cycles |
| sw_active | output | 1 | 1 while the switch is in the operated state |
| drv_en | output | 1 | Open-drain pull-down enable for the output pin |

## Verification
The hardest case to reach from the ports is a turn-on delay that is cancelled while it is still counting. The switch must enter the operated state and then receive a release sample a few cycles later, before the longest delay has run out. The bench selects the largest delay code and sends an operate sample. It waits three cycles, sends a sample below the release threshold, and then watches `drv_en` for a window well past the original deadline. The threshold edges are also covered. Exact threshold values are sent, followed by values one gauss further out, in both directions and at both ends of the code range.

// File: rtl/fsw_pkg.sv
package fsw_pkg;
    typedef enum logic {
        SW_RELEASED = 1'b0,
        SW_OPERATED = 1'b1
    } sw_state_e;

    typedef enum logic [1:0] {
        DR_IDLE  = 2'd0,
        DR_WAIT  = 2'd1,
        DR_DRIVE = 2'd2
    } drv_state_e;
endpackage

// File: rtl/fsw_threshold.sv
module fsw_threshold #(
    parameter int CODE_W = 8,
    parameter int TH_W   = 14,
    parameter int BASE_G = -20,
    parameter int STEP_G = 3,
    parameter int HYST_G = 15
) (
    input  logic [CODE_W-1:0]     op_code,
    input  logic                  op_dir,
    output logic signed [TH_W-1:0] op_th,
    output logic signed [TH_W-1:0] rel_th
);
    int mag_i;
    int op_i;
    int rel_i;

    // Linear scale on the code; direction mirrors its sign.
    always_comb begin
        mag_i  = BASE_G + STEP_G * int'(op_code);
        op_i   = op_dir ? -mag_i : mag_i;
        rel_i  = op_dir ? (op_i + HYST_G) : (op_i - HYST_G);
        op_th  = TH_W'(op_i);
        rel_th = TH_W'(rel_i);
    end
endmodule

// File: rtl/fsw_hyst_fsm.sv
module fsw_hyst_fsm
    import fsw_pkg::*;
#(
    parameter int TH_W = 14
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   pwr_ok,
    input  logic                   field_valid,
    input  logic signed [TH_W-1:0] field_x,
    input  logic signed [TH_W-1:0] op_th,
    input  logic signed [TH_W-1:0] rel_th,
    input  logic                   op_dir,
    output logic                   sw_active
);
    sw_state_e st_q;
    sw_state_e st_d;
    logic      beyond_op;
    logic      past_rel;

    // Direction picks which side of each threshold counts.
    always_comb begin
        beyond_op = op_dir ? (field_x < op_th)  : (field_x > op_th);
        past_rel  = op_dir ? (field_x > rel_th) : (field_x < rel_th);
    end

    always_comb begin
        st_d = st_q;
        if (!pwr_ok) begin
            st_d = SW_RELEASED;
        end else if (field_valid) begin
            unique case (st_q)
                SW_RELEASED: if (beyond_op) st_d = SW_OPERATED;
                SW_OPERATED: if (past_rel)  st_d = SW_RELEASED;
                default:     st_d = SW_RELEASED;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SW_RELEASED;
        else        st_q <= st_d;
    end

    always_comb begin
        sw_active = (st_q == SW_OPERATED);
    end

    p_hold_no_sample_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_ok && !field_valid) |=> $stable(sw_active));

    p_power_loss_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok |=> !sw_active);

    p_operate_taken_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_ok && field_valid && !sw_active && beyond_op) |=> sw_active);

    p_release_taken_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_ok && field_valid && sw_active && past_rel) |=> !sw_active);
endmodule

// File: rtl/fsw_drive_delay.sv
module fsw_drive_delay
    import fsw_pkg::*;
#(
    parameter int DLY_STEP = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       want_low,
    input  logic [1:0] fall_sel,
    output logic       drv_en
);
    localparam int MAX_WAIT = 3 * DLY_STEP;
    localparam int CNT_W    = $clog2(MAX_WAIT + 1);

    drv_state_e       ds_q;
    drv_state_e       ds_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W-1:0] load_val;

    always_comb begin
        load_val = CNT_W'(int'(fall_sel) * DLY_STEP - 1);
    end

    always_comb begin
        ds_d  = ds_q;
        cnt_d = cnt_q;
        unique case (ds_q)
            DR_IDLE: begin
                if (want_low) begin
                    if (fall_sel == 2'd0) begin
                        ds_d = DR_DRIVE;
                    end else begin
                        ds_d  = DR_WAIT;
                        cnt_d = load_val;
                    end
                end
            end
            DR_WAIT: begin
                if (!want_low)          ds_d = DR_IDLE;
                else if (cnt_q == '0)   ds_d = DR_DRIVE;
                else                    cnt_d = cnt_q - 1'b1;
            end
            DR_DRIVE: begin
                if (!want_low) ds_d = DR_IDLE;
            end
            default: ds_d = DR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ds_q  <= DR_IDLE;
            cnt_q <= '0;
        end else begin
            ds_q  <= ds_d;
            cnt_q <= cnt_d;
        end
    end

    // Release of the pull-down takes effect without a register stage.
    always_comb begin
        drv_en = (ds_q == DR_DRIVE) && want_low;
    end

    p_no_instant_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(want_low) |-> !drv_en);

    p_expiry_drives_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ds_q == DR_WAIT && want_low && cnt_q == '0) |=> (drv_en || !want_low));

    p_cancel_idles_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ds_q == DR_WAIT && !want_low) |=> !drv_en);
endmodule

// File: rtl/field_switch_top.sv
module field_switch_top #(
    parameter int FIELD_W  = 12,
    parameter int CODE_W   = 8,
    parameter int BASE_G   = -20,
    parameter int STEP_G   = 3,
    parameter int HYST_G   = 15,
    parameter int DLY_STEP = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      pwr_ok,
    input  logic                      field_valid,
    input  logic signed [FIELD_W-1:0] field,
    input  logic [CODE_W-1:0]         op_code,
    input  logic                      op_dir,
    input  logic                      out_inv,
    input  logic [1:0]                fall_sel,
    output logic                      sw_active,
    output logic                      drv_en
);
    localparam int TH_W = FIELD_W + 2;

    logic signed [TH_W-1:0] field_x;
    logic signed [TH_W-1:0] op_th;
    logic signed [TH_W-1:0] rel_th;
    logic                   want_low;

    always_comb begin
        field_x  = TH_W'(field);
        want_low = (sw_active != out_inv);
    end

    fsw_threshold #(
        .CODE_W (CODE_W),
        .TH_W   (TH_W),
        .BASE_G (BASE_G),
        .STEP_G (STEP_G),
        .HYST_G (HYST_G)
    ) u_thr (
        .op_code (op_code),
        .op_dir  (op_dir),
        .op_th   (op_th),
        .rel_th  (rel_th)
    );

    fsw_hyst_fsm #(
        .TH_W (TH_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .pwr_ok      (pwr_ok),
        .field_valid (field_valid),
        .field_x     (field_x),
        .op_th       (op_th),
        .rel_th      (rel_th),
        .op_dir      (op_dir),
        .sw_active   (sw_active)
    );

    fsw_drive_delay #(
        .DLY_STEP (DLY_STEP)
    ) u_drv (
        .clk      (clk),
        .rst_n    (rst_n),
        .want_low (want_low),
        .fall_sel (fall_sel),
        .drv_en   (drv_en)
    );

    p_drive_sense_r5: assert property (@(posedge clk) disable iff (!rst_n)
        drv_en |-> (sw_active != out_inv));

    p_poweron_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!pwr_ok) && !out_inv) |-> !drv_en);
endmodule

// File: tb/field_switch_top_tb.sv
module field_switch_top_tb;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              pwr_ok = 1'b0;
    logic              field_valid = 1'b0;
    logic signed [11:0] field = '0;
    logic [7:0]        op_code = '0;
    logic              op_dir = 1'b0;
    logic              out_inv = 1'b0;
    logic [1:0]        fall_sel = 2'd0;
    logic              sw_active;
    logic              drv_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    field_switch_top u_dut (
        .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .field_valid(field_valid),
        .field(field), .op_code(op_code), .op_dir(op_dir), .out_inv(out_inv),
        .fall_sel(fall_sel), .sw_active(sw_active), .drv_en(drv_en)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic send(input int v);
        @(negedge clk);
        field       = 12'(v);
        field_valid = 1'b1;
        @(negedge clk);
        field_valid = 1'b0;
    endtask

    task automatic setup(input int code, input bit dir, input bit inv, input int fs);
        @(negedge clk);
        op_code  = 8'(code);
        op_dir   = dir;
        out_inv  = inv;
        fall_sel = 2'(fs);
        pwr_ok   = 1'b0;
        @(negedge clk);
        pwr_ok   = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R6 reset sw_active", int'(sw_active), 0);
        chk("R6 reset drv_en", int'(drv_en), 0);
    endtask

    task automatic t_south;
        setup(10, 1'b0, 1'b0, 0);
        send(10);  chk("R1 at threshold holds", int'(sw_active), 0);
        send(11);  chk("R1 beyond threshold operates", int'(sw_active), 1);
        @(negedge clk); chk("R5 pin low when operated", int'(drv_en), 1);
        send(0);   chk("R2 inside band holds", int'(sw_active), 1);
        send(-5);  chk("R2 at release holds", int'(sw_active), 1);
        send(-6);  chk("R2 past release releases", int'(sw_active), 0);
        chk("R8 pin high at release", int'(drv_en), 0);
    endtask

    task automatic t_valid;
        setup(10, 1'b0, 1'b0, 0);
        @(negedge clk);
        field = 12'sd500;
        field_valid = 1'b0;
        repeat (4) @(negedge clk);
        chk("R4 unstrobed field ignored", int'(sw_active), 0);
        chk("R4 unstrobed field no drive", int'(drv_en), 0);
        send(11);
        @(negedge clk);
        field = -12'sd500;
        repeat (4) @(negedge clk);
        chk("R4 unstrobed release ignored", int'(sw_active), 1);
    endtask

    task automatic t_north;
        setup(10, 1'b1, 1'b0, 0);
        send(-10); chk("R3 at threshold holds", int'(sw_active), 0);
        send(-11); chk("R3 below threshold operates", int'(sw_active), 1);
        send(5);   chk("R3 at release holds", int'(sw_active), 1);
        send(6);   chk("R3 past release releases", int'(sw_active), 0);
    endtask

    task automatic t_extreme;
        setup(255, 1'b0, 1'b0, 0);
        send(745); chk("R10 top code at threshold", int'(sw_active), 0);
        send(746); chk("R10 top code operates", int'(sw_active), 1);
        send(730); chk("R10 top code at release", int'(sw_active), 1);
        send(729); chk("R10 top code releases", int'(sw_active), 0);
        setup(0, 1'b1, 1'b0, 0);
        send(20);  chk("R10 north code 0 at threshold", int'(sw_active), 0);
        send(19);  chk("R10 north code 0 operates", int'(sw_active), 1);
        send(35);  chk("R10 north code 0 at release", int'(sw_active), 1);
        send(36);  chk("R10 north code 0 releases", int'(sw_active), 0);
    endtask

    task automatic t_polarity;
        setup(10, 1'b0, 1'b1, 0);
        @(negedge clk);
        chk("R6 inverted power-on pin low", int'(drv_en), 1);
        send(11);
        chk("R8 inverted operate pin high", int'(drv_en), 0);
        chk("R5 inverted state", int'(sw_active), 1);
        send(-6);
        chk("R5 inverted release not yet", int'(drv_en), 0);
        @(negedge clk);
        chk("R5 inverted release pin low", int'(drv_en), 1);
    endtask

    task automatic t_delay(input int fs);
        setup(10, 1'b0, 1'b0, fs);
        @(negedge clk);
        field = 12'sd11;
        field_valid = 1'b1;
        @(posedge clk);
        #1 field_valid = 1'b0;
        repeat (4 * fs) @(posedge clk);
        @(negedge clk);
        chk($sformatf("R7 delay %0d not early", fs), int'(drv_en), 0);
        @(posedge clk);
        @(negedge clk);
        chk($sformatf("R7 delay %0d on time", fs), int'(drv_en), 1);
        send(-6);
        chk($sformatf("R8 delay %0d immediate off", fs), int'(drv_en), 0);
    endtask

    task automatic t_cancel;
        int highs = 0;
        setup(10, 1'b0, 1'b0, 3);
        send(11);
        repeat (3) @(negedge clk);
        send(-6);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (drv_en) highs++;
        end
        chk("R9 cancelled turn-on never drives", highs, 0);
        chk("R9 state released", int'(sw_active), 0);
    endtask

    task automatic t_power;
        setup(10, 1'b0, 1'b0, 0);
        send(11);
        chk("R6 operated before loss", int'(sw_active), 1);
        @(negedge clk);
        pwr_ok = 1'b0;
        @(negedge clk);
        pwr_ok = 1'b1;
        chk("R6 power loss releases", int'(sw_active), 0);
        chk("R6 power loss pin high", int'(drv_en), 0);
        @(negedge clk);
        pwr_ok = 1'b0;
        field = 12'sd50;
        field_valid = 1'b1;
        @(negedge clk);
        field_valid = 1'b0;
        pwr_ok = 1'b1;
        chk("R6 sample ignored without power", int'(sw_active), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        pwr_ok = 1'b1;
        @(negedge clk);
        t_reset();
        t_south();
        t_valid();
        t_north();
        t_extreme();
        t_polarity();
        for (int f = 0; f < 4; f++) t_delay(f);
        t_cancel();
        t_power();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule